// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

This block connects one processor-side bus (port A) to two memory-side buses: port 1B for the even bank and port 2B for the odd bank. Four independent transparent latches hold data in transit. Two latches carry A outward, one into each bank. Two latches carry each bank's data back toward A. A select input chooses which return latch drives A. The A bus can therefore be written into one or both banks in the same cycle, for interleaved writes, and read back from either bank, for address multiplexing.

Each bidirectional port is split into three parts: a data input, a data output and an active-high drive-enable output. Tri-state resolution happens outside the block. Three active-low output-enable inputs gate the drivers. Because the B-side enables are independent, one bank can be driven from A while the other bank is read back toward A.

The latches use a clocked equivalent model. While a latch enable is high, its output follows its input in the same cycle, and its store samples the input on every rising clock. Once the enable is low, the output shows the value the store took at the last rising clock edge at which the enable was high.

Top module: `tri_bus_xchg`

## Requirements
- R1: An active-low asynchronous reset clears all four latches to zero. After reset, with every latch enable low and every port enabled, all three data outputs read 0.
- R2: While `le_a_b1_i` is high and port 1B is enabled, `b1_o` equals `a_i` in the same cycle. While `le_a_b2_i` is high and port 2B is enabled, `b2_o` equals `a_i`.
- R3: While a latch enable is low, that latch's output holds the value its input had at the last rising clock edge at which the enable was high. Changes on the latch's data input have no effect on the output during that time.
- R4: Each of the four latch enables affects only its own latch. Freezing one outward latch leaves the other transparent, and the same holds for the two return latches.
- R5: When `sel_b1_i` is 1, port A is driven by the 1B-to-A latch output. When it is 0, port A is driven by the 2B-to-A latch output. The 1B-to-A latch is enabled by `le_b1_a_i` and the 2B-to-A latch by `le_b2_a_i`.
- R6: Each drive-enable output is the inverse of its active-low enable input: `a_oe_o = !oe_a_ni`, `b1_oe_o = !oe_b1_ni`, `b2_oe_o = !oe_b2_ni`. All eight combinations are independent.
- R7: A port whose enable input is high (disabled) presents all zeros on its data output.
- R8: In the same cycle, port 1B can be driven from A while port 2B is transparent back toward A, and the reverse also holds.
- R9: With both outward latch enables high, the same `a_i` value appears on `b1_o` and `b2_o` in the same cycle. After both enables fall, both ports keep that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the latch stores |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Data arriving on port A |
| a_o | output | W | Data driven onto port A |
| a_oe_o | output | 1 | Port A drive enable |
| b1_i | input | W | Data arriving on port 1B |
| b1_o | output | W | Data driven onto port 1B |
| b1_oe_o | output | 1 | Port 1B drive enable |
| b2_i | input | W | Data arriving on port 2B |
| b2_o | output | W | Data driven onto port 2B |
| b2_oe_o | output | 1 | Port 2B drive enable |
| le_a_b1_i | input | 1 | Enable of the A-to-1B latch |
| le_a_b2_i | input | 1 | Enable of the A-to-2B latch |
| le_b1_a_i | input | 1 | Enable of the 1B-to-A latch |
| le_b2_a_i | input | 1 | Enable of the 2B-to-A latch |
| sel_b1_i | input | 1 | Return select: 1 picks 1B, 0 picks 2B |
| oe_a_ni | input | 1 | Port A output enable, active low |
| oe_b1_ni | input | 1 | Port 1B output enable, active low |
| oe_b2_ni | input | 1 | Port 2B output enable, active low |

## Verification
The bench drives a single A value into both banks, then changes `a_i` after the enables fall. A latch that failed to hold would let the new value through to the B outputs. It freezes one outward latch while the other stays open, which catches enables that are swapped or shared between latches. It toggles the select with both return latches frozen, which exposes an inverted or stuck multiplexer. It also walks all eight output-enable combinations, where an inverted or cross-wired enable would drive a port that should be released or leave non-zero data on a disabled port.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned NUM_LATCH = 2 * NUM_BANKS;
  typedef enum logic {RET_B2 = 1'b0, RET_B1 = 1'b1} ret_sel_e;
endpackage

// File: rtl/xchg_latch.sv
// Transparent latch, clocked equivalent: pass-through while en_i, else hold.
module xchg_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (en_i) hold_q <= d_i;
  end

  assign q_o = en_i ? d_i : hold_q;
endmodule

// File: rtl/xchg_ret_mux.sv
module xchg_ret_mux #(
  parameter int unsigned W = 12
) (
  input  xchg_pkg::ret_sel_e sel_i,
  input  logic [W-1:0]       b1_i,
  input  logic [W-1:0]       b2_i,
  output logic [W-1:0]       y_o
);
  always_comb begin
    unique case (sel_i)
      xchg_pkg::RET_B1: y_o = b1_i;
      default:          y_o = b2_i;
    endcase
  end
endmodule

// File: rtl/xchg_port_drv.sv
// Split-port driver: data forced to zero when released.
module xchg_port_drv #(
  parameter int unsigned W = 12
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o,
  output logic         oe_o
);
  assign oe_o = ~oe_ni;
  assign d_o  = oe_ni ? '0 : d_i;
endmodule

// File: rtl/tri_bus_xchg.sv
module tri_bus_xchg #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b1_i,
  output logic [W-1:0] b1_o,
  output logic         b1_oe_o,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] b2_o,
  output logic         b2_oe_o,
  input  logic         le_a_b1_i,
  input  logic         le_a_b2_i,
  input  logic         le_b1_a_i,
  input  logic         le_b2_a_i,
  input  logic         sel_b1_i,
  input  logic         oe_a_ni,
  input  logic         oe_b1_ni,
  input  logic         oe_b2_ni
);
  import xchg_pkg::*;

  logic [NUM_BANKS-1:0][W-1:0] bank_in, out_q, ret_q;
  logic [NUM_BANKS-1:0]        out_en, ret_en, bank_oe_n, bank_oe;
  logic [NUM_BANKS-1:0][W-1:0] bank_out;
  logic [W-1:0]                ret_sel_d;

  assign bank_in   = {b2_i, b1_i};
  assign out_en    = {le_a_b2_i, le_a_b1_i};
  assign ret_en    = {le_b2_a_i, le_b1_a_i};
  assign bank_oe_n = {oe_b2_ni, oe_b1_ni};

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    xchg_latch #(.W(W)) u_out_lat (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(out_en[g]),
      .d_i   (a_i),   .q_o   (out_q[g])
    );
    xchg_latch #(.W(W)) u_ret_lat (
      .clk_i (clk_i), .rst_ni(rst_ni), .en_i(ret_en[g]),
      .d_i   (bank_in[g]), .q_o(ret_q[g])
    );
    xchg_port_drv #(.W(W)) u_drv (
      .oe_ni (bank_oe_n[g]), .d_i(out_q[g]),
      .d_o   (bank_out[g]),  .oe_o(bank_oe[g])
    );
  end

  xchg_ret_mux #(.W(W)) u_mux (
    .sel_i (sel_b1_i ? RET_B1 : RET_B2),
    .b1_i  (ret_q[0]),
    .b2_i  (ret_q[1]),
    .y_o   (ret_sel_d)
  );

  xchg_port_drv #(.W(W)) u_drv_a (
    .oe_ni (oe_a_ni), .d_i(ret_sel_d), .d_o(a_o), .oe_o(a_oe_o)
  );

  assign b1_o    = bank_out[0];
  assign b2_o    = bank_out[1];
  assign b1_oe_o = bank_oe[0];
  assign b2_oe_o = bank_oe[1];
endmodule

// File: rtl/xchg_chk.sv
module xchg_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b1_i,
  input logic [W-1:0] b1_o,
  input logic         b1_oe_o,
  input logic [W-1:0] b2_i,
  input logic [W-1:0] b2_o,
  input logic         b2_oe_o,
  input logic         le_a_b1_i,
  input logic         le_a_b2_i,
  input logic         le_b1_a_i,
  input logic         le_b2_a_i,
  input logic         sel_b1_i,
  input logic         oe_a_ni,
  input logic         oe_b1_ni,
  input logic         oe_b2_ni
);
  // R2
  b1_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_a_b1_i && !oe_b1_ni) |-> b1_o == a_i);
  // R2
  b2_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_a_b2_i && !oe_b2_ni) |-> b2_o == a_i);
  // R3
  b1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_a_b1_i && !oe_b1_ni && $past(!le_a_b1_i) && $past(!oe_b1_ni)) |-> $stable(b1_o));
  // R3
  b2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_a_b2_i && !oe_b2_ni && $past(!le_a_b2_i) && $past(!oe_b2_ni)) |-> $stable(b2_o));
  // R5
  ret_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni && sel_b1_i && le_b1_a_i) |-> a_o == b1_i);
  // R5
  ret_b2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_a_ni && !sel_b1_i && le_b2_a_i) |-> a_o == b2_i);
  // R7
  a_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_a_ni |-> (!a_oe_o && a_o == '0));
  // R7
  b1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_b1_ni |-> (!b1_oe_o && b1_o == '0));
  // R7
  b2_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_b2_ni |-> (!b2_oe_o && b2_o == '0));
endmodule

bind tri_bus_xchg xchg_chk #(.W(W)) u_xchg_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
  .b1_i(b1_i), .b1_o(b1_o), .b1_oe_o(b1_oe_o),
  .b2_i(b2_i), .b2_o(b2_o), .b2_oe_o(b2_oe_o),
  .le_a_b1_i(le_a_b1_i), .le_a_b2_i(le_a_b2_i),
  .le_b1_a_i(le_b1_a_i), .le_b2_a_i(le_b2_a_i),
  .sel_b1_i(sel_b1_i), .oe_a_ni(oe_a_ni), .oe_b1_ni(oe_b1_ni), .oe_b2_ni(oe_b2_ni)
);

// File: tb/tri_bus_xchg_tb_top.sv
`timescale 1ns/1ps
module tri_bus_xchg_tb_top;
  localparam int unsigned W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic le_a1 = 0, le_a2 = 0, le_r1 = 0, le_r2 = 0, sel = 0;
  logic oe_a_n = 0, oe_b1_n = 0, oe_b2_n = 0;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic a_oe, b1_oe, b2_oe;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_a1 = '0, m_a2 = '0, m_r1 = '0, m_r2 = '0;

  always #2.5 clk = ~clk;

  tri_bus_xchg #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe),
    .b1_i(b1_i), .b1_o(b1_o), .b1_oe_o(b1_oe),
    .b2_i(b2_i), .b2_o(b2_o), .b2_oe_o(b2_oe),
    .le_a_b1_i(le_a1), .le_a_b2_i(le_a2), .le_b1_a_i(le_r1), .le_b2_a_i(le_r2),
    .sel_b1_i(sel), .oe_a_ni(oe_a_n), .oe_b1_ni(oe_b1_n), .oe_b2_ni(oe_b2_n)
  );

  function automatic logic [W-1:0] lat(logic en, logic [W-1:0] d, logic [W-1:0] s);
    return en ? d : s;
  endfunction
  function automatic logic [W-1:0] drv(logic oe_n, logic [W-1:0] v);
    return oe_n ? '0 : v;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs already set after a falling edge; check mid-cycle, then update the model.
  task automatic tick(string tag);
    #1;
    chk({tag, " R2 b1_o"}, b1_o, drv(oe_b1_n, lat(le_a1, a_i, m_a1)));
    chk({tag, " R2 b2_o"}, b2_o, drv(oe_b2_n, lat(le_a2, a_i, m_a2)));
    chk({tag, " R5 a_o"}, a_o, drv(oe_a_n, sel ? lat(le_r1, b1_i, m_r1) : lat(le_r2, b2_i, m_r2)));
    chk({tag, " R6 a_oe"}, W'(a_oe), W'(!oe_a_n));
    chk({tag, " R6 b1_oe"}, W'(b1_oe), W'(!oe_b1_n));
    chk({tag, " R6 b2_oe"}, W'(b2_oe), W'(!oe_b2_n));
    @(posedge clk);
    if (le_a1) m_a1 = a_i;
    if (le_a2) m_a2 = a_i;
    if (le_r1) m_r1 = b1_i;
    if (le_r2) m_r2 = b2_i;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, all enables low, all ports driving
    #1;
    chk("R1 b1_o", b1_o, '0);
    chk("R1 b2_o", b2_o, '0);
    chk("R1 a_o sel=0", a_o, '0);
    @(negedge clk);

    // R9: A into both banks at once, then hold after both enables drop
    a_i = 12'hABC; le_a1 = 1; le_a2 = 1; tick("r9_both");
    le_a1 = 0; le_a2 = 0; a_i = 12'h123; tick("r9_hold");
    chk("R9 b1 held", b1_o, 12'hABC);
    chk("R9 b2 held", b2_o, 12'hABC);

    // R4/R3: freeze 2B latch, keep 1B transparent
    a_i = 12'h555; le_a1 = 1; tick("r4_one_open");
    #1; chk("R4 b1 open", b1_o, 12'h555); chk("R3 b2 frozen", b2_o, 12'hABC);
    @(negedge clk); le_a1 = 0;

    // R5: load return latches, freeze, toggle select
    b1_i = 12'h111; b2_i = 12'h222; le_r1 = 1; le_r2 = 1; tick("r5_load");
    le_r1 = 0; le_r2 = 0; b1_i = 12'hF0F; b2_i = 12'h0F0;
    sel = 1; tick("r5_sel1");
    #1; chk("R5 sel=1 picks 1B", a_o, 12'h111); @(negedge clk);
    sel = 0; tick("r5_sel0");
    #1; chk("R5 sel=0 picks 2B", a_o, 12'h222); @(negedge clk);

    // R8: drive 1B from A while 2B reads back to A
    oe_b2_n = 1; le_r2 = 1; b2_i = 12'h3C3; sel = 0; a_i = 12'h777; le_a1 = 1;
    tick("r8_split");
    #1; chk("R8 a from 2B", a_o, 12'h3C3); chk("R8 b1 from A", b1_o, 12'h777);
    chk("R7 b2 released", b2_o, '0);
    @(negedge clk); le_r2 = 0; le_a1 = 0; oe_b2_n = 0;

    // R6/R7: every output-enable combination
    for (int k = 0; k < 8; k++) begin
      {oe_a_n, oe_b1_n, oe_b2_n} = 3'(k);
      tick("r6_r7_oe");
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      a_i = W'($urandom); b1_i = W'($urandom); b2_i = W'($urandom);
      {le_a1, le_a2, le_r1, le_r2} = 4'($urandom);
      sel = 1'($urandom);
      {oe_a_n, oe_b1_n, oe_b2_n} = 3'($urandom) & 3'($urandom);
      tick("rnd R3 R4 R7 R8");
    end
    summary();
  end
endmodule